// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block keeps four word-wide storage registers arranged as two first-level slots (A1, B1) and two second-level slots (A2, B2), all written from a single data input on the rising clock edge. A 2-bit operation code chosen each cycle lets the four registers behave as two independent two-deep pipelines, or as one four-deep shift chain. Any one of the four registers can be read out through a combinational selector, and an active-low output enable gates the read port.

A compile-time variant parameter fixes the first-level load rule. With push-down selected, a load into a first-level slot moves that pipeline's previous first-level word into its second-level slot in the same clock. With overwrite selected, a first-level load replaces only the first-level word, and the second level is written only by the four-deep shift operation. The read port drives zero and drops a valid flag when disabled, so no tristate is needed.

Top module: `mlp_pipe_reg`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero at the next rising edge.
- R2: Operation code 3 leaves all four registers unchanged.
- R3: Operation code 0 shifts the chain: A1 takes the input word, A2 takes old A1, B1 takes old A2, B2 takes old B1; old B2 is lost.
- R4: Operation code 2 writes the input word into A1 and leaves B1 and B2 unchanged.
- R5: Operation code 1 writes the input word into B1 and leaves A1 and A2 unchanged.
- R6: In the push-down variant (PUSHDOWN=1), code 2 also copies old A1 into A2, and code 1 copies old B1 into B2, in the same clock.
- R7: In the overwrite variant (PUSHDOWN=0), codes 1 and 2 leave A2 and B2 unchanged.
- R8: The read select picks B2 on 00, B1 on 01, A2 on 10 and A1 on 11, and acts within the same cycle without a clock edge.
- R9: With oe_n high the output word is zero and y_valid is 0; with oe_n low y_valid is 1 and the selected word appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | W | Data word to be stored |
| op | input | 2 | Operation code: 0 shift, 1 load B1, 2 load A1, 3 hold |
| rd_sel | input | 2 | Read select: 00 B2, 01 B1, 10 A2, 11 A1 |
| oe_n | input | 1 | Active-low read enable |
| y_out | output | W | Selected register word, zero when disabled |
| y_valid | output | 1 | High when the read port is enabled |

## Verification
The bench builds two copies at the default 8-bit width, one with PUSHDOWN=1 and one with PUSHDOWN=0, and drives both with the same operation stream so each variant's load rule is compared against its own arithmetic model. After every clock it sweeps all four read-select codes, which exposes the full content of both pipelines each cycle. A long stream mixing every operation code with varied data words reaches chains of repeated shifts, back-to-back loads and holds, plus a reset in mid-run and both states of the read enable.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  typedef enum logic [1:0] {
    OP_SHIFT  = 2'd0,
    OP_LOAD_B = 2'd1,
    OP_LOAD_A = 2'd2,
    OP_HOLD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PICK_B2 = 2'd0,
    PICK_B1 = 2'd1,
    PICK_A2 = 2'd2,
    PICK_A1 = 2'd3
  } pick_e;

  typedef struct packed {
    logic we_a1;
    logic we_a2;
    logic we_b1;
    logic we_b2;
    logic chain;
  } ctl_s;

  // Write enables per register for a given operation and load rule.
  function automatic ctl_s decode_op(op_e code, bit push);
    ctl_s c;
    c = '0;
    unique case (code)
      OP_SHIFT: begin
        c.we_a1 = 1'b1; c.we_a2 = 1'b1;
        c.we_b1 = 1'b1; c.we_b2 = 1'b1;
        c.chain = 1'b1;
      end
      OP_LOAD_A: begin
        c.we_a1 = 1'b1;
        c.we_a2 = push;
      end
      OP_LOAD_B: begin
        c.we_b1 = 1'b1;
        c.we_b2 = push;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
#(
  parameter bit PUSHDOWN = 1'b1
) (
  input  logic [1:0] op,
  output ctl_s       ctl
);
  op_e code_w;
  assign code_w = op_e'(op);
  assign ctl    = decode_op(code_w, PUSHDOWN);

  // R3: a chain step always writes every register
  always_comb begin
    assert_chain_all_R3: assert (!ctl.chain || (ctl.we_a1 && ctl.we_a2 && ctl.we_b1 && ctl.we_b2));
  end
endmodule

// File: rtl/mlp_regbank.sv
module mlp_regbank
  import mlp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ctl_s         ctl,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] a1,
  output logic [W-1:0] a2,
  output logic [W-1:0] b1,
  output logic [W-1:0] b2
);
  logic [W-1:0] b1_src_w;

  // B1 is fed from A2 during a chain step, otherwise from the input
  assign b1_src_w = ctl.chain ? a2 : d_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0;
      a2 <= '0;
      b1 <= '0;
      b2 <= '0;
    end else begin
      if (ctl.we_a1) a1 <= d_in;
      if (ctl.we_a2) a2 <= a1;
      if (ctl.we_b1) b1 <= b1_src_w;
      if (ctl.we_b2) b2 <= b1;
    end
  end
endmodule

// File: rtl/mlp_outsel.sv
module mlp_outsel
  import mlp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   rd_sel,
  input  logic         oe_n,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] b2,
  output logic [W-1:0] y_out,
  output logic         y_valid
);
  logic [W-1:0] pick_w;

  always_comb begin
    unique case (pick_e'(rd_sel))
      PICK_B2: pick_w = b2;
      PICK_B1: pick_w = b1;
      PICK_A2: pick_w = a2;
      default: pick_w = a1;
    endcase
  end

  assign y_valid = ~oe_n;
  assign y_out   = oe_n ? '0 : pick_w;
endmodule

// File: rtl/mlp_pipe_reg.sv
module mlp_pipe_reg
  import mlp_pkg::*;
#(
  parameter int W        = 8,
  parameter bit PUSHDOWN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic [1:0]   op,
  input  logic [1:0]   rd_sel,
  input  logic         oe_n,
  output logic [W-1:0] y_out,
  output logic         y_valid
);
  ctl_s         ctl_w;
  logic [W-1:0] a1_w, a2_w, b1_w, b2_w;

  mlp_ctrl #(.PUSHDOWN(PUSHDOWN)) ctrl_i (
    .op  (op),
    .ctl (ctl_w)
  );

  mlp_regbank #(.W(W)) bank_i (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl_w),
    .d_in (d_in),
    .a1   (a1_w),
    .a2   (a2_w),
    .b1   (b1_w),
    .b2   (b2_w)
  );

  mlp_outsel #(.W(W)) outsel_i (
    .rd_sel  (rd_sel),
    .oe_n    (oe_n),
    .a1      (a1_w),
    .a2      (a2_w),
    .b1      (b1_w),
    .b2      (b2_w),
    .y_out   (y_out),
    .y_valid (y_valid)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (a1_w == '0 && a2_w == '0 && b1_w == '0 && b2_w == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd3) |=> ($stable(a1_w) && $stable(a2_w) && $stable(b1_w) && $stable(b2_w)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd0) |=> (a1_w == $past(d_in) && a2_w == $past(a1_w) &&
                      b1_w == $past(a2_w) && b2_w == $past(b1_w)));

  assert_load_a_R4: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd2) |=> (a1_w == $past(d_in) && $stable(b1_w) && $stable(b2_w)));

  assert_load_b_R5: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1) |=> (b1_w == $past(d_in) && $stable(a1_w) && $stable(a2_w)));

  generate
    if (PUSHDOWN) begin : g_push
      assert_push_a_R6: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd2) |=> (a2_w == $past(a1_w)));
      assert_push_b_R6: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd1) |=> (b2_w == $past(b1_w)));
    end else begin : g_over
      assert_keep_second_R7: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd1 || op == 2'd2) |=> ($stable(a2_w) && $stable(b2_w)));
    end
  endgenerate

  assert_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (y_out == '0 && !y_valid));
endmodule

// File: tb/mlp_pipe_reg_tb_top.sv
`timescale 1ns/1ps
module mlp_pipe_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] d_in = '0;
  logic [1:0]   op = 2'd3;
  logic [1:0]   rd_sel = 2'd0;
  logic         oe_n = 1'b0;
  logic [W-1:0] y_p, y_o;
  logic         v_p, v_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state: index 0 push-down, 1 overwrite; order a1,a2,b1,b2
  logic [W-1:0] ma1 [2];
  logic [W-1:0] ma2 [2];
  logic [W-1:0] mb1 [2];
  logic [W-1:0] mb2 [2];

  always #2.5 clk = ~clk;

  mlp_pipe_reg #(.W(W), .PUSHDOWN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .d_in(d_in), .op(op), .rd_sel(rd_sel),
    .oe_n(oe_n), .y_out(y_p), .y_valid(v_p));

  mlp_pipe_reg #(.W(W), .PUSHDOWN(1'b0)) dut_ow_i (
    .clk(clk), .rst(rst), .d_in(d_in), .op(op), .rd_sel(rd_sel),
    .oe_n(oe_n), .y_out(y_o), .y_valid(v_o));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_pick(int v, int s);
    case (s)
      0: return mb2[v];
      1: return mb1[v];
      2: return ma2[v];
      default: return ma1[v];
    endcase
  endfunction

  task automatic model_clear();
    for (int v = 0; v < 2; v++) begin
      ma1[v] = '0; ma2[v] = '0; mb1[v] = '0; mb2[v] = '0;
    end
  endtask

  task automatic model_step(input int code, input logic [W-1:0] d);
    for (int v = 0; v < 2; v++) begin
      case (code)
        0: begin
          mb2[v] = mb1[v]; mb1[v] = ma2[v]; ma2[v] = ma1[v]; ma1[v] = d;
        end
        1: begin
          if (v == 0) mb2[v] = mb1[v];
          mb1[v] = d;
        end
        2: begin
          if (v == 0) ma2[v] = ma1[v];
          ma1[v] = d;
        end
        default: ;
      endcase
    end
  endtask

  // sweep all four selects (R8) on both variants, between edges
  task automatic sweep(input string tag);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.3;
      check({tag, " R8 R6 push sel"}, int'(y_p), int'(model_pick(0, s)));
      check({tag, " R8 R7 over sel"}, int'(y_o), int'(model_pick(1, s)));
    end
  endtask

  task automatic step(input int code, input logic [W-1:0] d);
    string tag;
    case (code)
      0: tag = "R3";
      1: tag = "R5";
      2: tag = "R4";
      default: tag = "R2";
    endcase
    @(negedge clk);
    op   = 2'(code);
    d_in = d;
    @(posedge clk);
    model_step(code, d);
    #0.2;
    op = 2'd3;
    sweep(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    model_clear();
    #0.2;
    rst = 1'b0;
    sweep("R1");
  endtask

  initial begin
    model_clear();
    do_reset();

    // fill with shifts, then mixed stream covering all codes
    for (int i = 0; i < 6; i++) step(0, W'(8'h11 * (i + 1)));
    for (int i = 0; i < 300; i++) begin
      int code;
      code = ((i * 7) + (i / 5)) % 4;
      step(code, W'((i * 37 + 5) & 8'hFF));
    end
    // back-to-back first-level loads
    for (int i = 0; i < 4; i++) step(2, W'(8'hA0 + i));
    for (int i = 0; i < 4; i++) step(1, W'(8'hB0 + i));
    for (int i = 0; i < 3; i++) step(3, 8'hFF);

    // R9: disabled port reads zero, valid low, for every select
    @(negedge clk);
    oe_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.3;
      check("R9 push data off", int'(y_p), 0);
      check("R9 over data off", int'(y_o), 0);
      check("R9 push valid off", int'(v_p), 0);
      check("R9 over valid off", int'(v_o), 0);
    end
    oe_n = 1'b0;
    #0.3;
    check("R9 push valid on", int'(v_p), 1);
    check("R9 over valid on", int'(v_o), 1);

    // R1: reset from a loaded state
    do_reset();
    step(0, 8'h5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule